// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

A direct-mapped data cache that sits between a processor request port and a slower lower-level memory port. It holds 32 lines of eight 32-bit words each (1 KB) and serves word reads and writes on a 32-bit byte address. A request is held on the processor port until the cycle in which the controller raises `cpu_ready`. A hit completes in the cycle it is presented. A miss stalls the processor while whole blocks move over the memory port, one word per `mem_ready` beat.

Two elaboration-time parameters set the write policy. `WRITE_BACK` selects write-back (1) or write-through (0) on a write hit. `WRITE_ALLOC` selects whether a write miss fetches the block (1) or goes to memory only (0). On the same access trace the chosen pair changes the hit and miss counts, whether victims are written back, and how many memory writes occur. Two counters expose the number of hits and misses so that this difference can be checked.

Top module: `dmc_cache`

## Requirements
- R1: The byte address is split into tag = bits 31..10, line index = bits 9..5, word within block = bits 4..2. Bits 1..0 are ignored. A request hits only when the indexed line is valid and its stored tag equals the address tag. Two addresses that share an index but differ in tag displace each other.
- R2: A read hit raises `cpu_ready` in the same cycle the request is presented, returns the stored word on `cpu_rdata`, and makes no memory request.
- R3: With `WRITE_BACK`=1, a write hit updates only the cached word, completes with no wait cycle, and issues no memory write.
- R4: With `WRITE_BACK`=0, a write hit updates the cached word and also issues exactly one memory write of that word. `cpu_ready` rises in the cycle that write is accepted.
- R5: With `WRITE_ALLOC`=1, a write miss first fetches the whole block and then completes as a write hit. A later read of that address hits.
- R6: With `WRITE_ALLOC`=0, a write miss sends one memory write and leaves the cache untouched. A later read of that address misses and returns the written value from memory.
- R7: A line is dirty after a write under write-back. It is clean after each refill. A miss whose victim is dirty first writes all eight victim words, at the victim's own addresses, before any refill beat. A clean victim causes no memory write.
- R8: A refill reads the eight words of the block in ascending word order. `mem_req` is held with a stable address until `mem_ready` accepts each beat. The requested word is then returned.
- R9: From the cycle a miss is detected, `cpu_ready` stays low until the read word is returned or the write is complete. `cpu_ready` is only ever high while `cpu_req` is high.
- R10: Each request adds exactly one to either `hit_count` or `miss_count`. From an empty cache the trace write 100, read 200, write 200, write 100 yields 2 misses and 2 hits with write-allocate, and 3 misses and 1 hit with no-write-allocate.
- R11: A synchronous reset clears every valid bit, every dirty bit and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` on a read |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word |
| mem_ready | input | 1 | Memory accepts or returns the current beat |
| hit_count | output | 16 | Number of hits since reset |
| miss_count | output | 16 | Number of misses since reset |

## Verification
Two instances run side by side: one with write-back plus write-allocate, and one with write-through plus no-write-allocate. Each is driven with the same four-access trace. Their hit and miss counts and their memory write totals separate the two policy pairs. A conflicting address that maps to a dirty line tells eviction-before-refill apart from a plain refill. Reading the same address again after a clean victim shows that a second write-back does not occur. Reads of the first and last words of a refilled block, together with wait-cycle counts on hits and misses, show the beat order and the stall window.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVICT,
      ST_FILL,
      ST_RESP,
      ST_WMEM
   } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES      = 32,
   parameter int TAG_W      = 22,
   parameter bit WRITE_BACK = 1'b1,
   localparam int IDX_W     = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] idx,
   input  logic             install,
   input  logic [TAG_W-1:0] new_tag,
   input  logic             dirty_set,
   output logic             line_valid,
   output logic [TAG_W-1:0] line_tag,
   output logic             line_dirty
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (rst) valid_q <= '0;
      else if (install) valid_q[idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (install) tag_q[idx] <= new_tag;
   end

   assign line_valid = valid_q[idx];
   assign line_tag   = tag_q[idx];

   if (WRITE_BACK) begin : g_dirty
      logic [LINES-1:0] dirty_q;
      always_ff @(posedge clk) begin
         if (rst) dirty_q <= '0;
         else if (install) dirty_q[idx] <= 1'b0;
         else if (dirty_set) dirty_q[idx] <= 1'b1;
      end
      assign line_dirty = dirty_q[idx];
   end else begin : g_clean
      logic unused_dirty_set;
      assign unused_dirty_set = dirty_set;
      assign line_dirty = 1'b0;
   end
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int LINES      = 32,
   parameter int LINE_WORDS = 8,
   parameter int DATA_W     = 32,
   localparam int IDX_W     = $clog2(LINES),
   localparam int BEAT_W    = $clog2(LINE_WORDS),
   localparam int DEPTH     = LINES * LINE_WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wr_en,
   input  logic [BEAT_W-1:0] wr_word,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BEAT_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[{idx, wr_word}] <= wr_data;
   end

   assign rd_data = mem_q[{idx, rd_word}];
endmodule

// File: rtl/dmc_counters.sv
module dmc_counters #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit_inc,
   input  logic             miss_inc,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] miss_count
);
   always_ff @(posedge clk) begin
      if (rst) begin
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         if (hit_inc)  hit_count  <= hit_count + CNT_W'(1);
         if (miss_inc) miss_count <= miss_count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int LINES       = 32,
   parameter int LINE_WORDS  = 8,
   parameter int CNT_W       = 16,
   parameter bit WRITE_BACK  = 1'b1,
   parameter bit WRITE_ALLOC = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);
   import dmc_pkg::*;

   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int BEAT_W = $clog2(LINE_WORDS);
   localparam int OFF_W  = BYTE_W + BEAT_W;
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

   if (DATA_W % 8 != 0 || DATA_W < 16 || (LINES & (LINES - 1)) != 0 || LINES < 2 ||
       (LINE_WORDS & (LINE_WORDS - 1)) != 0 || LINE_WORDS < 2 || TAG_W < 1 || CNT_W < 1)
   begin : g_bad_params
      $error("dmc_cache: unsupported parameter combination");
   end

   dmc_state_e        state_q, state_d;
   logic [BEAT_W-1:0] beat_q;
   logic              beat_adv;
   logic              last_beat;

   logic [IDX_W-1:0]  req_idx;
   logic [TAG_W-1:0]  req_tag;
   logic [BEAT_W-1:0] req_word;
   logic              line_valid, line_dirty, hit;
   logic [TAG_W-1:0]  line_tag;
   logic              install, dirty_set, hit_inc, miss_inc;
   logic              dat_we;
   logic [BEAT_W-1:0] dat_wword, dat_rword;
   logic [DATA_W-1:0] dat_wdata, dat_rdata;

   assign req_idx   = cpu_addr[OFF_W +: IDX_W];
   assign req_tag   = cpu_addr[OFF_W + IDX_W +: TAG_W];
   assign req_word  = cpu_addr[BYTE_W +: BEAT_W];
   assign hit       = line_valid && (line_tag == req_tag);
   assign last_beat = (beat_q == BEAT_W'(LINE_WORDS - 1));
   assign cpu_rdata = dat_rdata;

   dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)) u_tags (
      .clk(clk), .rst(rst), .idx(req_idx), .install(install), .new_tag(req_tag),
      .dirty_set(dirty_set), .line_valid(line_valid), .line_tag(line_tag),
      .line_dirty(line_dirty)
   );

   dmc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
      .clk(clk), .idx(req_idx), .wr_en(dat_we), .wr_word(dat_wword), .wr_data(dat_wdata),
      .rd_word(dat_rword), .rd_data(dat_rdata)
   );

   dmc_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .hit_inc(hit_inc), .miss_inc(miss_inc),
      .hit_count(hit_count), .miss_count(miss_count)
   );

   always_comb begin
      state_d   = state_q;
      cpu_ready = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = dat_rdata;
      dat_we    = 1'b0;
      dat_wword = req_word;
      dat_wdata = cpu_wdata;
      dat_rword = req_word;
      install   = 1'b0;
      dirty_set = 1'b0;
      hit_inc   = 1'b0;
      miss_inc  = 1'b0;
      beat_adv  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (cpu_req) begin
            hit_inc  = hit;
            miss_inc = !hit;
            if (hit) begin
               if (cpu_we && !WRITE_BACK) state_d = ST_WMEM;
               else begin
                  cpu_ready = 1'b1;
                  dat_we    = cpu_we;
                  dirty_set = cpu_we;
               end
            end else if (cpu_we && !WRITE_ALLOC) state_d = ST_WMEM;
            else if (line_dirty) state_d = ST_EVICT;
            else state_d = ST_FILL;
         end
         ST_EVICT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            dat_rword = beat_q;
            mem_addr  = {line_tag, req_idx, beat_q, {BYTE_W{1'b0}}};
            if (mem_ready) begin
               beat_adv = 1'b1;
               if (last_beat) state_d = ST_FILL;
            end
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {req_tag, req_idx, beat_q, {BYTE_W{1'b0}}};
            if (mem_ready) begin
               beat_adv  = 1'b1;
               dat_we    = 1'b1;
               dat_wword = beat_q;
               dat_wdata = mem_rdata;
               if (last_beat) begin
                  install = 1'b1;
                  state_d = (cpu_we && !WRITE_BACK) ? ST_WMEM : ST_RESP;
               end
            end
         end
         ST_RESP: begin
            cpu_ready = 1'b1;
            dat_we    = cpu_we;
            dirty_set = cpu_we;
            state_d   = ST_IDLE;
         end
         ST_WMEM: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cpu_addr & ~ADDR_W'(DATA_W / 8 - 1);
            mem_wdata = cpu_wdata;
            if (mem_ready) begin
               cpu_ready = 1'b1;
               dat_we    = hit;
               state_d   = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         if (beat_adv) beat_q <= beat_q + BEAT_W'(1);
      end
   end
endmodule

module dmc_cache_chk #(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 16,
   parameter bit WRITE_BACK  = 1'b1,
   parameter bit WRITE_ALLOC = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  miss_count
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else past_ok <= 1'b1;
   end

   p_ready_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |-> cpu_req);

   p_miss_stalls_r9: assert property (@(posedge clk) disable iff (rst || !past_ok)
      (miss_count != $past(miss_count)) |-> $past(!cpu_ready));

   p_hit_step_r10: assert property (@(posedge clk) disable iff (rst || !past_ok)
      (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + CNT_W'(1)));

   p_one_counter_r10: assert property (@(posedge clk) disable iff (rst || !past_ok)
      !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));

   p_mem_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   p_read_done_no_mem_r2: assert property (@(posedge clk) disable iff (rst)
      (cpu_ready && !cpu_we) |-> !mem_req);

   if (WRITE_BACK && WRITE_ALLOC) begin : g_wb_wa
      p_wb_write_only_evict_r3: assert property (@(posedge clk) disable iff (rst)
         (mem_req && mem_we) |-> !cpu_ready);
   end
endmodule

bind dmc_cache dmc_cache_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)
) u_chk (
   .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
   .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
   .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/dmc_cache_tb.sv
module dmc_mem_model (
   input  logic        clk,
   input  logic        rst,
   input  logic        req,
   input  logic        we,
   input  logic [31:0] addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        ready
);
   logic [31:0] arr [1024];
   int wr_count;

   initial begin
      for (int i = 0; i < 1024; i++) arr[i] = 32'hA000_0000 | i;
      wr_count = 0;
   end

   assign rdata = arr[addr[11:2]];

   always_ff @(posedge clk) begin
      if (rst) ready <= 1'b0;
      else ready <= req && !ready;
      if (req && we && ready) begin
         arr[addr[11:2]] <= wdata;
         wr_count <= wr_count + 1;
      end
   end
endmodule

module dmc_cache_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int total = 0;
   int bad = 0;

   logic        req_a = 0, we_a = 0, req_b = 0, we_b = 0;
   logic [31:0] addr_a = 0, wdata_a = 0, addr_b = 0, wdata_b = 0;
   logic [31:0] rdata_a, rdata_b;
   logic        rdy_a, rdy_b;
   logic        mreq_a, mwe_a, mrdy_a, mreq_b, mwe_b, mrdy_b;
   logic [31:0] maddr_a, mwd_a, mrd_a, maddr_b, mwd_b, mrd_b;
   logic [15:0] hits_a, miss_a, hits_b, miss_b;

   dmc_cache #(.WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) u_dut (
      .clk(clk), .rst(rst), .cpu_req(req_a), .cpu_we(we_a), .cpu_addr(addr_a),
      .cpu_wdata(wdata_a), .cpu_rdata(rdata_a), .cpu_ready(rdy_a),
      .mem_req(mreq_a), .mem_we(mwe_a), .mem_addr(maddr_a), .mem_wdata(mwd_a),
      .mem_rdata(mrd_a), .mem_ready(mrdy_a), .hit_count(hits_a), .miss_count(miss_a)
   );

   dmc_cache #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) u_dut_nwa (
      .clk(clk), .rst(rst), .cpu_req(req_b), .cpu_we(we_b), .cpu_addr(addr_b),
      .cpu_wdata(wdata_b), .cpu_rdata(rdata_b), .cpu_ready(rdy_b),
      .mem_req(mreq_b), .mem_we(mwe_b), .mem_addr(maddr_b), .mem_wdata(mwd_b),
      .mem_rdata(mrd_b), .mem_ready(mrdy_b), .hit_count(hits_b), .miss_count(miss_b)
   );

   dmc_mem_model u_mem_a (.clk(clk), .rst(rst), .req(mreq_a), .we(mwe_a), .addr(maddr_a),
      .wdata(mwd_a), .rdata(mrd_a), .ready(mrdy_a));
   dmc_mem_model u_mem_b (.clk(clk), .rst(rst), .req(mreq_b), .we(mwe_b), .addr(maddr_b),
      .wdata(mwd_b), .rdata(mrd_b), .ready(mrdy_b));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic access(input bit sel, input bit we, input logic [31:0] addr,
                         input logic [31:0] wd, output logic [31:0] rd, output int waits);
      waits = 0;
      @(negedge clk);
      if (sel) begin req_b = 1; we_b = we; addr_b = addr; wdata_b = wd; end
      else begin req_a = 1; we_a = we; addr_a = addr; wdata_a = wd; end
      #1;
      while (!(sel ? rdy_b : rdy_a) && waits < 300) begin
         @(negedge clk); #1;
         waits++;
      end
      rd = sel ? rdata_b : rdata_a;
      @(negedge clk);
      if (sel) req_b = 0; else req_a = 0;
   endtask

   task automatic t_reset_state();
      check("R11 hit_count after reset", 32'(hits_a), 0);
      check("R11 miss_count after reset", 32'(miss_a), 0);
      check("R9 no ready while idle", 32'(rdy_a), 0);
      check("R8 no mem_req while idle", 32'(mreq_a), 0);
   endtask

   task automatic t_trace_wb_wa();
      logic [31:0] rd; int w;
      access(0, 1, 32'd100, 32'h1111_0064, rd, w);
      check("R9 write-allocate miss stalls", 32'(w >= 8), 1);
      access(0, 0, 32'd200, 0, rd, w);
      check("R8 read miss returns refilled word", rd, 32'hA000_0032);
      access(0, 1, 32'd200, 32'h2222_00C8, rd, w);
      check("R3 write-back write hit no wait", w, 0);
      access(0, 1, 32'd100, 32'h3333_0064, rd, w);
      check("R10 write-allocate misses", 32'(miss_a), 2);
      check("R10 write-allocate hits", 32'(hits_a), 2);
      check("R3 write-back hits cause no memory writes", u_mem_a.wr_count, 0);
      access(0, 0, 32'd100, 0, rd, w);
      check("R5 allocated write reads back as hit", rd, 32'h3333_0064);
      check("R2 read hit has no wait", w, 0);
      check("R5 read after allocate counted as hit", 32'(hits_a), 3);
   endtask

   task automatic t_trace_wt_nwa();
      logic [31:0] rd; int w;
      access(1, 1, 32'd100, 32'h1111_0064, rd, w);
      access(1, 0, 32'd200, 0, rd, w);
      access(1, 1, 32'd200, 32'h2222_00C8, rd, w);
      check("R4 write-through hit waits for memory", 32'(w > 0), 1);
      access(1, 1, 32'd100, 32'h3333_0064, rd, w);
      check("R10 no-write-allocate misses", 32'(miss_b), 3);
      check("R10 no-write-allocate hits", 32'(hits_b), 1);
      check("R4 R6 memory writes", u_mem_b.wr_count, 3);
      access(1, 0, 32'd200, 0, rd, w);
      check("R4 write-through updated cache", rd, 32'h2222_00C8);
      access(1, 0, 32'd100, 0, rd, w);
      check("R6 line not allocated by write miss", 32'(miss_b), 4);
      check("R6 memory holds written word", rd, 32'h3333_0064);
   endtask

   task automatic t_evict();
      logic [31:0] rd; int w;
      access(0, 0, 32'd1124, 0, rd, w);
      check("R7 dirty victim written back in full", u_mem_a.wr_count, 8);
      check("R7 evict then refill word", rd, 32'hA000_0119);
      check("R9 stall covers evict and refill", 32'(w >= 16), 1);
      check("R1 conflicting tag misses", 32'(miss_a), 3);
      access(0, 0, 32'd100, 0, rd, w);
      check("R7 clean victim causes no write", u_mem_a.wr_count, 8);
      check("R7 victim data reached memory", rd, 32'h3333_0064);
      access(0, 0, 32'h7C, 0, rd, w);
      check("R8 last word of block", rd, 32'hA000_001F);
      access(0, 0, 32'h62, 0, rd, w);
      check("R1 byte bits ignored, first word", rd, 32'hA000_0018);
      check("R1 same block hits", 32'(hits_a), 5);
   endtask

   task automatic t_mid_reset();
      logic [31:0] rd; int w;
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      check("R11 counters cleared", 32'(hits_a + miss_a), 0);
      access(0, 0, 32'd100, 0, rd, w);
      check("R11 valid bits cleared", 32'(miss_a), 1);
      check("R11 data from memory after reset", rd, 32'h3333_0064);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      #1;
      t_reset_state();
      t_trace_wb_wa();
      t_trace_wt_nwa();
      t_evict();
      t_mid_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule